// File: doc/BRIEF.md
# Prioritized Interrupt Level Gate

This block sits between up to seven peripheral interrupt request lines and a processor core. It finds the most urgent active request and encodes it as a 3-bit level. It then compares that level with a 3-bit processor priority threshold and raises a pending signal only when the request beats the threshold. The request lines can come from other clock domains, so they pass through a two-flop synchronizer. The encoded level must then hold for two samples in a row before it counts, which filters out single-cycle glitches.

The threshold is loaded in two ways: through a write port, or automatically when the core acknowledges an interrupt. On an acknowledge, the threshold takes the accepted level, so only strictly higher requests can interrupt the handler. Level 7 is treated as non-maskable. When the threshold is 7, a fresh rise of level 7 still raises pending once. The request must fall before it can raise pending again.

Top module: `irq_level_gate`

## Requirements
- R1: Input bit i of `irq_lines` (i = 0..6) is request level i+1. `int_level` shows the highest-numbered active request, and 0 when no line is active.
- R2: A change on `irq_lines` made just before clock edge E1 appears on `int_level` after edge E4, not earlier. A request that is present for only one clock never changes `int_level`.
- R3: `int_pending` is high when `int_level` is strictly greater than `mask_level`. With `mask_level` at 7, levels 1 to 6 never raise it.
- R4: With `mask_level` at 0, every nonzero level raises `int_pending`.
- R5: With `mask_level` at 7, a rise of `int_level` to 7 raises `int_pending` one clock later. It stays high until acknowledged. A level-7 request that is held after the acknowledge does not raise it again until the level has dropped and risen again.
- R6: When `int_ack` is high while `int_pending` is high, after the next edge `ack_valid` is high for one cycle, `ack_level` and `mask_level` both equal the accepted level, and `int_pending` is low unless a higher level is present.
- R7: `int_ack` while `int_pending` is low has no effect: `ack_valid` stays low and `mask_level` is unchanged.
- R8: `mask_we` loads `mask_wdata` into `mask_level` at the next edge. When a write and an accepted acknowledge happen in the same cycle, the acknowledged level is loaded instead.
- R9: After reset, `mask_level` is 7, and `int_pending`, `int_level` and `ack_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 7 | Request lines; bit i is level i+1 |
| mask_we | input | 1 | Threshold write enable |
| mask_wdata | input | 3 | Threshold write value |
| int_ack | input | 1 | Acknowledge from the core |
| int_pending | output | 1 | Interrupt pending towards the core |
| int_level | output | 3 | Qualified encoded request level |
| mask_level | output | 3 | Current priority threshold |
| ack_valid | output | 1 | One-cycle pulse after an accepted acknowledge |
| ack_level | output | 3 | Level that was accepted |

## Verification
For each threshold from 0 to 6, the bench walks through all 128 combinations of the request lines. This tells apart a correct highest-bit encoder from one that picks the wrong end, and shows where the strict greater-than boundary sits. It also checks one clock before the level settles, which shows the exact synchronizer and stability delay. At threshold 7 it sweeps the patterns without level 7 to show full blocking. Directed sequences then cover the one-shot behaviour of level 7, a one-cycle glitch, an acknowledge that collides with a write, and an acknowledge with nothing pending.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  localparam int NUM_LINES = 7;
  localparam int LVL_W     = $clog2(NUM_LINES + 1);
  localparam logic [LVL_W-1:0] TOP_LEVEL = LVL_W'(NUM_LINES);

  // Bit i of the request vector stands for level i+1; the highest wins.
  function automatic logic [LVL_W-1:0] highest_level(input logic [NUM_LINES-1:0] req);
    logic [LVL_W-1:0] lvl;
    lvl = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (req[i]) lvl = LVL_W'(i + 1);
    end
    return lvl;
  endfunction

  // Maskable path: the request must strictly beat the threshold.
  function automatic logic level_exceeds(input logic [LVL_W-1:0] lvl,
                                         input logic [LVL_W-1:0] thr);
    return lvl > thr;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[k] <= '0;
          else        stage_q[k] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[k] <= '0;
          else        stage_q[k] <= stage_q[k-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/irq_level_filter.sv
module irq_level_filter
  import irq_gate_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] sync_req,
  output logic [LVL_W-1:0]     enc_lvl,
  output logic [LVL_W-1:0]     qual_lvl
);

  logic [LVL_W-1:0] prev_enc;
  logic             settled;

  assign enc_lvl = highest_level(sync_req);
  assign settled = (enc_lvl == prev_enc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_enc <= '0;
      qual_lvl <= '0;
    end else begin
      prev_enc <= enc_lvl;
      if (settled) qual_lvl <= enc_lvl;
    end
  end

  // R1: no active line encodes as level zero, and the reverse.
  always_comb begin
    if (rst_n) begin
      p_zero_level_r1: assert ((sync_req == '0) == (enc_lvl == '0));
    end
  end

  // R2: a new qualified level was seen on the encoder two clocks back.
  p_qual_settled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(qual_lvl) |-> $past(enc_lvl, 2) == qual_lvl);

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LVL_W-1:0] wr_data,
  input  logic             take,
  input  logic [LVL_W-1:0] take_lvl,
  output logic [LVL_W-1:0] mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= TOP_LEVEL;
    else if (take)  mask_q <= take_lvl;
    else if (wr_en) mask_q <= wr_data;
  end

  p_write_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !take) |=> mask_q == $past(wr_data));

  p_ack_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> mask_q == $past(take_lvl));

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !take) |=> $stable(mask_q));

endmodule

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 mask_we,
  input  logic [LVL_W-1:0]     mask_wdata,
  input  logic                 int_ack,
  output logic                 int_pending,
  output logic [LVL_W-1:0]     int_level,
  output logic [LVL_W-1:0]     mask_level,
  output logic                 ack_valid,
  output logic [LVL_W-1:0]     ack_level
);

  logic [NUM_LINES-1:0] sync_req;
  logic [LVL_W-1:0]     enc_lvl;
  logic [LVL_W-1:0]     qual_lvl;
  logic                 top_prev;
  logic                 top_rise;
  logic                 nmi_latch;
  logic                 maskable_hit;
  logic                 ack_take;
  logic [LVL_W-1:0]     accept_lvl;

  irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_lines),
    .q     (sync_req)
  );

  irq_level_filter u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_req (sync_req),
    .enc_lvl  (enc_lvl),
    .qual_lvl (qual_lvl)
  );

  // Non-maskable path: a fresh rise to the top level while fully masked.
  assign top_rise     = (qual_lvl == TOP_LEVEL) && !top_prev;
  assign maskable_hit = level_exceeds(qual_lvl, mask_level);
  assign int_pending  = maskable_hit || nmi_latch;
  assign ack_take     = int_ack && int_pending;
  assign accept_lvl   = nmi_latch ? TOP_LEVEL : qual_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_prev  <= 1'b0;
      nmi_latch <= 1'b0;
    end else begin
      top_prev <= (qual_lvl == TOP_LEVEL);
      if (ack_take)
        nmi_latch <= 1'b0;
      else if (top_rise && (mask_level == TOP_LEVEL))
        nmi_latch <= 1'b1;
    end
  end

  irq_mask_reg u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (mask_we),
    .wr_data  (mask_wdata),
    .take     (ack_take),
    .take_lvl (accept_lvl),
    .mask_q   (mask_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack_level <= '0;
    end else begin
      ack_valid <= ack_take;
      if (ack_take) ack_level <= accept_lvl;
    end
  end

  assign int_level = qual_lvl;

  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_level == TOP_LEVEL && !nmi_latch) |-> !int_pending);

  p_nmi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_latch && !int_ack) |=> nmi_latch);

  p_ack_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> ack_valid && (mask_level == ack_level) && !nmi_latch);

  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(int_ack));

  p_idle_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_pending) |=> !ack_valid);

endmodule

// File: tb/tb_irq_level_gate.sv
module tb_irq_level_gate;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] irq_lines = '0;
  logic       mask_we = 1'b0;
  logic [2:0] mask_wdata = '0;
  logic       int_ack = 1'b0;
  logic       int_pending;
  logic [2:0] int_level;
  logic [2:0] mask_level;
  logic       ack_valid;
  logic [2:0] ack_level;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  irq_level_gate dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_lines   (irq_lines),
    .mask_we     (mask_we),
    .mask_wdata  (mask_wdata),
    .int_ack     (int_ack),
    .int_pending (int_pending),
    .int_level   (int_level),
    .mask_level  (mask_level),
    .ack_valid   (ack_valid),
    .ack_level   (ack_level)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Scan from the top line downwards: the first set line gives the level.
  function automatic int model_level(input logic [6:0] p);
    for (int b = 6; b >= 0; b--) if (p[b]) return b + 1;
    return 0;
  endfunction

  task automatic write_mask(input int m);
    mask_we = 1'b1; mask_wdata = 3'(m);
    tick(1);
    mask_we = 1'b0;
    check("R8 write loads threshold", mask_level, m);
  endtask

  initial begin
    #1000000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int prev;
    @(negedge clk);
    tick(3);
    check("R9 reset threshold", mask_level, 7);
    check("R9 reset pending", int_pending, 0);
    check("R9 reset level", int_level, 0);
    check("R9 reset ack_valid", ack_valid, 0);
    rst_n = 1'b1;
    tick(2);

    // R1 R2 R3 R4: full sweep per maskable threshold.
    prev = 0;
    for (int m = 0; m < 7; m++) begin
      write_mask(m);
      for (int p = 0; p < 128; p++) begin
        int e;
        e = model_level(7'(p));
        irq_lines = 7'(p);
        tick(3);
        check("R2 level not yet settled", int_level, prev);
        tick(1);
        check("R1 encoded level", int_level, e);
        check(m == 0 ? "R4 open threshold pending" : "R3 pending vs threshold",
              int_pending, (e > m) ? 1 : 0);
        prev = e;
      end
    end

    // R3: threshold 7 blocks all levels below 7.
    write_mask(7);
    for (int p = 0; p < 64; p++) begin
      irq_lines = 7'(p);
      tick(4);
      check("R3 full threshold blocks", int_pending, 0);
    end
    irq_lines = '0;
    tick(6);

    // R2: one-cycle glitch is filtered.
    irq_lines = 7'b0000100;
    tick(1);
    irq_lines = '0;
    tick(8);
    check("R2 glitch ignored", int_level, 0);

    // R5: non-maskable top level, one shot per rise.
    irq_lines = 7'b1000000;
    tick(4);
    check("R5 level seen", int_level, 7);
    check("R5 not before latch", int_pending, 0);
    tick(1);
    check("R5 top level fires", int_pending, 1);
    tick(3);
    check("R5 held until ack", int_pending, 1);
    int_ack = 1'b1;
    tick(1);
    int_ack = 1'b0;
    check("R6 ack_valid after top ack", ack_valid, 1);
    check("R6 ack_level top", ack_level, 7);
    check("R6 pending cleared", int_pending, 0);
    check("R6 threshold stays 7", mask_level, 7);
    tick(10);
    check("R5 no refire while held", int_pending, 0);
    check("R6 ack_valid is one pulse", ack_valid, 0);
    irq_lines = '0;
    tick(6);
    irq_lines = 7'b1000000;
    tick(5);
    check("R5 refires after drop", int_pending, 1);
    int_ack = 1'b1;
    tick(1);
    int_ack = 1'b0;
    irq_lines = '0;
    tick(6);

    // R6: acknowledge raises the threshold to the accepted level.
    write_mask(2);
    irq_lines = 7'b0010000;
    tick(4);
    check("R3 level 5 over threshold 2", int_pending, 1);
    int_ack = 1'b1;
    tick(1);
    int_ack = 1'b0;
    check("R6 ack_valid", ack_valid, 1);
    check("R6 ack_level", ack_level, 5);
    check("R6 threshold loaded", mask_level, 5);
    check("R6 pending cleared", int_pending, 0);

    // R8: ack beats a simultaneous write.
    irq_lines = 7'b0110000;
    tick(4);
    check("R3 level 6 over threshold 5", int_pending, 1);
    int_ack = 1'b1; mask_we = 1'b1; mask_wdata = 3'd1;
    tick(1);
    int_ack = 1'b0; mask_we = 1'b0;
    check("R8 ack wins threshold", mask_level, 6);
    check("R8 ack level on collision", ack_level, 6);

    // R7: ack with nothing pending.
    tick(2);
    check("R7 nothing pending", int_pending, 0);
    int_ack = 1'b1;
    tick(1);
    int_ack = 1'b0;
    check("R7 no ack_valid", ack_valid, 0);
    check("R7 threshold unchanged", mask_level, 6);
    check("R7 ack_level unchanged", ack_level, 6);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule